// File: doc/BRIEF.md
# Data-Processing Cycle Sequencer

This block orders the bus cycles of one data-processing instruction in a pipelined 32-bit core. A one-clock start strobe comes with two qualifiers. The first says the shift amount is taken from a register. The second says the instruction writes the program counter. From these the block walks through its cycles: an optional internal cycle, then the first instruction fetch, then two refill fetches when the program counter is written.

Each active cycle is labelled on a two-bit cycle-type output. On the first refill fetch the block raises a refill request for one clock. Done is high for one clock on the last cycle of the instruction. The block also gives the value that register 15 shows when an instruction reads it as an operand. That value is worked out from the instruction address that comes with the start strobe.

Start is a plain control strobe, not a stream. A start is taken only while the block is idle, or in the cycle where done is high, so instructions can run back to back with no gap. At any other time a start is dropped. The memory interface and the arithmetic datapath are left to neighbouring blocks.

Top module: `dp_cycle_seq`

## Requirements
- R1: After reset, busy_o, done_o and refill_o are 0 and cyc_type_o is 2'b00 (idle), and they stay that way until a start is taken.
- R2: start_i is taken only while busy_o is 0 or done_o is 1. A start (with any qualifiers and address) seen in any other cycle has no effect on the cycle trace or on pc_operand_o.
- R3: With both qualifiers low, the instruction is a single cycle of type 2'b10 (sequential fetch) in the clock after the start is taken.
- R4: With reg_shift_i high and pc_write_i low, the instruction is one internal cycle (2'b01) and then one sequential fetch (2'b10): two cycles in total.
- R5: With pc_write_i high and reg_shift_i low, the instruction is a sequential fetch (2'b10), then a nonsequential fetch (2'b11), then a sequential fetch (2'b10): three cycles in total.
- R6: With both qualifiers high, the instruction is an internal cycle (2'b01) and then the three fetches of R5: four cycles in total.
- R7: refill_o is high for exactly one clock per program-counter write, on the nonsequential refill fetch, and it is never high otherwise.
- R8: done_o is high for exactly one clock per instruction, on its last cycle, and busy_o is high on every cycle of the instruction.
- R9: On every cycle of an instruction, pc_operand_o equals the instruction address plus 8 when reg_shift_i was low, and plus 12 when it was high (modulo 2^32).
- R10: When a start is taken in the done cycle, the next instruction's first cycle follows in the very next clock, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for one instruction |
| reg_shift_i | input | 1 | The shift amount comes from a register |
| pc_write_i | input | 1 | The instruction writes the program counter |
| instr_addr_i | input | 32 | Address of the instruction being started |
| busy_o | output | 1 | An instruction is in progress in this cycle |
| cyc_type_o | output | 2 | Cycle type: 00 idle, 01 internal, 10 sequential fetch, 11 nonsequential fetch |
| refill_o | output | 1 | Pipeline refill request, on the first refill fetch |
| done_o | output | 1 | Last cycle of the instruction |
| pc_operand_o | output | 32 | Value of register 15 when read as an operand |

## Verification
The hardest case to reach is a start that lands in the done cycle while the previous instruction had different qualifiers. The qualifiers must be captured at that edge, even though the old ones still decide the current cycle. The stimulus drives the next start together with its qualifiers in the very sampling slot where done is seen. It chains all four combinations in every order, both directed and at random. It also holds start high with random qualifiers and addresses during the middle cycles, which checks that those starts are dropped.

// File: rtl/dpseq_pkg.sv
package dpseq_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE = 2'b00,
    CYC_INT  = 2'b01,
    CYC_SEQ  = 2'b10,
    CYC_NSEQ = 2'b11
  } cyc_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_INT   = 3'd1,
    ST_FETCH = 3'd2,
    ST_REF1  = 3'd3,
    ST_REF2  = 3'd4
  } state_e;
endpackage

// File: rtl/dpseq_ctrl.sv
module dpseq_ctrl
  import dpseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic reg_shift_i,
  input  logic pc_write_i,
  output logic accept_o,
  output logic busy_o,
  output logic done_o,
  output logic refill_o,
  output cyc_e cyc_o
);
  state_e st_q, st_d;
  logic   pw_q;

  // final cycle of the instruction in flight
  always_comb begin
    done_o = (st_q == ST_FETCH && !pw_q) || (st_q == ST_REF2);
  end

  assign busy_o   = (st_q != ST_IDLE);
  assign accept_o = start_i && (!busy_o || done_o);
  assign refill_o = (st_q == ST_REF1);

  always_comb begin
    st_d = st_q;
    if (accept_o) begin
      st_d = reg_shift_i ? ST_INT : ST_FETCH;
    end else begin
      case (st_q)
        ST_IDLE:  st_d = ST_IDLE;
        ST_INT:   st_d = ST_FETCH;
        ST_FETCH: st_d = pw_q ? ST_REF1 : ST_IDLE;
        ST_REF1:  st_d = ST_REF2;
        ST_REF2:  st_d = ST_IDLE;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      pw_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept_o) pw_q <= pc_write_i;
    end
  end

  always_comb begin
    case (st_q)
      ST_INT:   cyc_o = CYC_INT;
      ST_FETCH: cyc_o = CYC_SEQ;
      ST_REF1:  cyc_o = CYC_NSEQ;
      ST_REF2:  cyc_o = CYC_SEQ;
      default:  cyc_o = CYC_IDLE;
    endcase
  end

  // R8: without a new start, the done cycle is followed by idle
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> !done_o && !busy_o);

  // R2: a mid-instruction cycle always leads to another busy cycle
  p_mid_keeps_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !done_o |=> busy_o);

  // R4: the internal cycle is followed by the first sequential fetch
  p_int_then_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_o == CYC_INT |=> cyc_o == CYC_SEQ && !refill_o);

  // R7: the refill fetch is followed by the final sequential fetch
  p_refill_then_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    refill_o |=> cyc_o == CYC_SEQ && done_o && !refill_o);

  // R1: idle means no done and no refill
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !done_o && !refill_o && cyc_o == CYC_IDLE);
endmodule

// File: rtl/dpseq_pcgen.sv
module dpseq_pcgen #(
  parameter int ADDR_W    = 32,
  parameter int AHEAD_IMM = 8,
  parameter int AHEAD_REG = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              reg_shift_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              busy_i,
  input  logic              done_i,
  output logic [ADDR_W-1:0] pc_o
);
  localparam logic [ADDR_W-1:0] OFF_IMM = ADDR_W'(AHEAD_IMM);
  localparam logic [ADDR_W-1:0] OFF_REG = ADDR_W'(AHEAD_REG);

  logic [ADDR_W-1:0] pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (accept_i) begin
      pc_q <= addr_i + (reg_shift_i ? OFF_REG : OFF_IMM);
    end
  end

  assign pc_o = pc_q;

  // R9: the operand value is held across the whole instruction
  p_pc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i && !done_i |=> $stable(pc_o));
endmodule

// File: rtl/dp_cycle_seq.sv
module dp_cycle_seq
  import dpseq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int AHEAD_IMM = 8,
  parameter int AHEAD_REG = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              reg_shift_i,
  input  logic              pc_write_i,
  input  logic [ADDR_W-1:0] instr_addr_i,
  output logic              busy_o,
  output logic [1:0]        cyc_type_o,
  output logic              refill_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] pc_operand_o
);
  logic accept;
  cyc_e cyc;

  dpseq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .reg_shift_i (reg_shift_i),
    .pc_write_i  (pc_write_i),
    .accept_o    (accept),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .refill_o    (refill_o),
    .cyc_o       (cyc)
  );

  dpseq_pcgen #(
    .ADDR_W    (ADDR_W),
    .AHEAD_IMM (AHEAD_IMM),
    .AHEAD_REG (AHEAD_REG)
  ) u_pcgen (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept),
    .reg_shift_i (reg_shift_i),
    .addr_i      (instr_addr_i),
    .busy_i      (busy_o),
    .done_i      (done_o),
    .pc_o        (pc_operand_o)
  );

  assign cyc_type_o = cyc;

  // R10: a start taken in the done cycle keeps the block busy next clock
  p_back_to_back_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && start_i |=> busy_o);
endmodule

// File: tb/dp_cycle_seq_tb.sv
module dp_cycle_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        reg_shift_i = 1'b0;
  logic        pc_write_i = 1'b0;
  logic [31:0] instr_addr_i = '0;
  logic        busy_o, refill_o, done_o;
  logic [1:0]  cyc_type_o;
  logic [31:0] pc_operand_o;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  dp_cycle_seq u_dut (
    .clk (clk), .rst_n (rst_n), .start_i (start_i),
    .reg_shift_i (reg_shift_i), .pc_write_i (pc_write_i),
    .instr_addr_i (instr_addr_i), .busy_o (busy_o),
    .cyc_type_o (cyc_type_o), .refill_o (refill_o),
    .done_o (done_o), .pc_operand_o (pc_operand_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_len(input bit rs, input bit pw);
    return 1 + int'(rs) + 2 * int'(pw);
  endfunction

  function automatic logic [1:0] exp_type(input bit rs, input int i);
    int j;
    if (rs && i == 0) return 2'b01;
    j = i - int'(rs);
    return (j == 1) ? 2'b11 : 2'b10;
  endfunction

  function automatic logic [31:0] exp_pc(input bit rs, input logic [31:0] a);
    return a + (rs ? 32'd12 : 32'd8);
  endfunction

  task automatic drive(input bit s, input bit rs, input bit pw,
                       input logic [31:0] a);
    start_i = s; reg_shift_i = rs; pc_write_i = pw; instr_addr_i = a;
  endtask

  // Start for (rs,pw,a) is already driven; follow it to its end.
  task automatic follow(input bit rs, input bit pw, input logic [31:0] a,
                        input bit nxt, input bit nrs, input bit npw,
                        input logic [31:0] na, input bit junk);
    int len;
    len = exp_len(rs, pw);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      chk(cyc_type_o == exp_type(rs, i), (rs ? (pw ? "R6 type" : "R4 type")
          : (pw ? "R5 type" : "R3 type")), 32'(cyc_type_o), 32'(exp_type(rs, i)));
      chk(done_o == (i == len - 1), "R8 done", 32'(done_o), 32'(i == len - 1));
      chk(busy_o == 1'b1, "R8 busy", 32'(busy_o), 32'd1);
      chk(refill_o == (pw && i == int'(rs) + 1), "R7 refill",
          32'(refill_o), 32'(pw && i == int'(rs) + 1));
      chk(pc_operand_o == exp_pc(rs, a), "R9 pc", pc_operand_o, exp_pc(rs, a));
      if (i == len - 1) begin
        if (nxt) drive(1'b1, nrs, npw, na);
        else drive(1'b0, 1'b0, 1'b0, 32'h0);
      end else if (junk) begin
        // R2: a start here must be dropped
        drive(1'($urandom), 1'($urandom), 1'($urandom), $urandom);
      end else begin
        drive(1'b0, 1'b0, 1'b0, 32'h0);
      end
    end
  endtask

  task automatic expect_idle(input string req);
    @(negedge clk);
    chk(busy_o == 1'b0 && cyc_type_o == 2'b00 && !done_o && !refill_o, req,
        {busy_o, cyc_type_o, done_o, refill_o}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit rs, pw, nrs, npw;
    logic [31:0] a, na;
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    // R1: reset state, also while reset is held
    chk(busy_o == 0 && cyc_type_o == 2'b00 && !done_o && !refill_o,
        "R1 in reset", {busy_o, cyc_type_o, done_o, refill_o}, 32'h0);
    rst_n = 1'b1;
    expect_idle("R1 after reset");
    expect_idle("R1 idle hold");

    // R3..R6 isolated, each followed by idle
    for (int k = 0; k < 4; k++) begin
      rs = k[0]; pw = k[1]; a = 32'h1000 + 32'(k * 4);
      drive(1'b1, rs, pw, a);
      follow(rs, pw, a, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
      expect_idle("R8 idle after done");
    end

    // R10: all combos chained back to back, with wrap of the address
    a = 32'hFFFF_FFF8; rs = 1'b1; pw = 1'b1;
    drive(1'b1, rs, pw, a);
    for (int k = 0; k < 4; k++) begin
      nrs = k[1]; npw = k[0]; na = 32'h2000 + 32'(k * 16);
      follow(rs, pw, a, 1'b1, nrs, npw, na, 1'b0);
      rs = nrs; pw = npw; a = na;
    end
    follow(rs, pw, a, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
    expect_idle("R10 idle after chain");

    // R2: junk starts during the middle cycles
    drive(1'b1, 1'b1, 1'b1, 32'h3000);
    follow(1'b1, 1'b1, 32'h3000, 1'b0, 1'b0, 1'b0, 32'h0, 1'b1);
    expect_idle("R2 junk ignored");

    // random mix
    rs = 1'($urandom); pw = 1'($urandom); a = $urandom;
    drive(1'b1, rs, pw, a);
    for (int n = 0; n < 400; n++) begin
      bit chain;
      chain = ($urandom % 4) != 0;
      nrs = 1'($urandom); npw = 1'($urandom); na = $urandom;
      follow(rs, pw, a, chain, nrs, npw, na, 1'($urandom));
      if (!chain) begin
        expect_idle("R8 idle random");
        drive(1'b1, nrs, npw, na);
      end
      rs = nrs; pw = npw; a = na;
    end
    follow(rs, pw, a, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
    expect_idle("R1 final idle");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule